// File: doc/BRIEF.md
# PPS-Gated Reference Frequency Calibrator

This block measures how far a synthesizer's reference oscillator sits from its nominal frequency. A divided synthesizer output drives the block's clock. A one-pulse-per-second timing input sets the measurement window. After a start request, the block counts clock cycles from the first PPS rising edge to the edge a fixed number of pulses later. With the default settings the clock is a 2.5 MHz tap derived from the reference and the window is 40 seconds, so an exact reference gives 100,000,000 counts.

When the window closes, the block scales the count down by a power of two to give an inferred reference frequency. Dividing by four yields hertz of the reference. It then subtracts that frequency from a nominal value to form a signed correction, and raises a one-cycle strobe. An uncalibrated crystal can run several kilohertz high, so the correction holds negative values of that size.

A PPS source that stalls aborts the run and raises a sticky error flag. The flag stays set until the next start. The block is built around one state machine with four states:

- IDLE: waiting for start.
- ARM: waiting for the first PPS edge.
- GATE: counting.
- PUBLISH: strobing the result.

The state machine has five named transitions:

- accept (IDLE to ARM on start).
- open (ARM to GATE on a PPS edge).
- close (GATE to PUBLISH on the final edge).
- abort (ARM or GATE to IDLE when PPS times out).
- retire (PUBLISH to IDLE).

Top module: `refcal_top`

## Requirements
- R1: After reset `valid_o` and `error_o` are 0, and `count_o`, `ref_hz_o` and `corr_o` are all zero.
- R2: PPS edges seen while IDLE have no effect: no strobe and no error. A run starts counting on the first PPS rising edge detected after start is accepted.
- R3: `count_o` equals the number of clock cycles between the opening PPS edge and the GATE_PULSES-th PPS edge after it. For a PPS period of P cycles this is GATE_PULSES*P.
- R4: `ref_hz_o` equals `count_o` shifted right by SCALE_SHIFT bits, which truncates toward zero.
- R5: `corr_o` is a two's complement value CNT_W+1 bits wide equal to NOMINAL minus `ref_hz_o`. It is negative when the reference runs above nominal.
- R6: `valid_o` is high for exactly one cycle per completed window. The new results are already on the outputs in that cycle, and they are held unchanged until the next completed window.
- R7: A start request while a run is in ARM or GATE is ignored, and the open window completes with unchanged results.
- R8: If more than PPS_TIMEOUT clock cycles pass without a PPS edge while in ARM or GATE, the run is aborted. `error_o` is set, no strobe is issued and previous results are kept.
- R9: `error_o` stays set until a new start is accepted in IDLE, which clears it.
- R10: PPS passes through a two-flop synchronizer and only its rising edge is used, so a pulse held high for many cycles counts as a single edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Measured clock (divided synthesizer output) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_in | input | 1 | Asynchronous one-pulse-per-second timing input |
| start | input | 1 | Request one calibration run |
| count_o | output | CNT_W | Raw cycle count of the last window |
| ref_hz_o | output | CNT_W-SCALE_SHIFT | Inferred reference frequency |
| corr_o | output | CNT_W+1 | Signed correction, nominal minus inferred |
| valid_o | output | 1 | One-cycle strobe when new results are ready |
| error_o | output | 1 | Sticky PPS timeout flag |

## Verification
The bound assertions check four things on every cycle:

- The strobe is a single cycle.
- The result outputs move only in the cycle just before a strobe.
- The error flag stays set until a start arrives, and never coincides with a strobe.
- The machine leaves IDLE only on start.

The bench scenarios are needed to show the arithmetic results: exact counts for several PPS periods and pulse widths, truncation in the scaling, and negative corrections. They also show start requests ignored mid-window, pre-start PPS pulses ignored, and aborts in both ARM and GATE.

// File: rtl/refcal_pkg.sv
package refcal_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_ARM     = 2'd1,
        S_GATE    = 2'd2,
        S_PUBLISH = 2'd3
    } state_t;
endpackage

// File: rtl/refcal_pps_sync.sv
module refcal_pps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_async,
    output logic pps_rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= pps_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign pps_rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/refcal_timeout.sv
module refcal_timeout #(
    parameter int LIMIT = 3_750_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] tmr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            tmr_q <= '0;
        else if (!run || kick) tmr_q <= '0;
        else                   tmr_q <= tmr_q + 1'b1;
    end

    assign expired = run && !kick && (tmr_q == TW'(LIMIT - 1));
endmodule

// File: rtl/refcal_result.sv
module refcal_result #(
    parameter int CNT_W       = 28,
    parameter int SCALE_SHIFT = 2,
    parameter int NOMINAL     = 25_000_000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [CNT_W-1:0]         cnt_in,
    output logic [CNT_W-1:0]         count_q,
    output logic [CNT_W-SCALE_SHIFT-1:0] ref_q,
    output logic signed [CNT_W:0]    corr_q
);
    localparam int RW = CNT_W - SCALE_SHIFT;
    localparam logic [CNT_W:0] NOM_X = (CNT_W + 1)'(NOMINAL);

    logic [RW-1:0]         ref_next;
    logic signed [CNT_W:0] corr_next;

    always_comb begin
        ref_next  = cnt_in[CNT_W-1:SCALE_SHIFT];
        corr_next = $signed(NOM_X) - $signed({{(SCALE_SHIFT + 1){1'b0}}, ref_next});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            ref_q   <= '0;
            corr_q  <= '0;
        end else if (load) begin
            count_q <= cnt_in;
            ref_q   <= ref_next;
            corr_q  <= corr_next;
        end
    end
endmodule

// File: rtl/refcal_top.sv
module refcal_top
    import refcal_pkg::*;
#(
    parameter int CNT_W       = 28,
    parameter int GATE_PULSES = 40,
    parameter int SCALE_SHIFT = 2,
    parameter int NOMINAL     = 25_000_000,
    parameter int PPS_TIMEOUT = 3_750_000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pps_in,
    input  logic                          start,
    output logic [CNT_W-1:0]              count_o,
    output logic [CNT_W-SCALE_SHIFT-1:0]  ref_hz_o,
    output logic signed [CNT_W:0]         corr_o,
    output logic                          valid_o,
    output logic                          error_o
);
    localparam int GW = $clog2(GATE_PULSES + 1);
    localparam logic [GW-1:0] LAST_EDGE = GW'(GATE_PULSES - 1);

    state_t          state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [GW-1:0]   edges_q;
    logic            err_q;
    logic            pps_rise, expired, run, close_win, abort_run;

    refcal_pps_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pps_async (pps_in),
        .pps_rise  (pps_rise)
    );

    assign run = (state_q == S_ARM) || (state_q == S_GATE);

    refcal_timeout #(.LIMIT(PPS_TIMEOUT)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .kick    (pps_rise),
        .expired (expired)
    );

    assign abort_run = run && expired;
    assign close_win = (state_q == S_GATE) && pps_rise && (edges_q == LAST_EDGE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_ARM;              // accept
            S_ARM: begin
                if (expired)       state_d = S_IDLE;            // abort
                else if (pps_rise) state_d = S_GATE;            // open
            end
            S_GATE: begin
                if (expired)        state_d = S_IDLE;           // abort
                else if (close_win) state_d = S_PUBLISH;        // close
            end
            S_PUBLISH:              state_d = S_IDLE;           // retire
            default:                state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // window counters and sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            edges_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (state_q == S_ARM && pps_rise) begin
                cnt_q   <= '0;
                edges_q <= '0;
            end else if (state_q == S_GATE) begin
                cnt_q <= cnt_q + 1'b1;
                if (pps_rise) edges_q <= edges_q + 1'b1;
            end
            if (state_q == S_IDLE && start) err_q <= 1'b0;
            else if (abort_run)             err_q <= 1'b1;
        end
    end

    refcal_result #(
        .CNT_W       (CNT_W),
        .SCALE_SHIFT (SCALE_SHIFT),
        .NOMINAL     (NOMINAL)
    ) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (close_win),
        .cnt_in  (cnt_q + 1'b1),
        .count_q (count_o),
        .ref_q   (ref_hz_o),
        .corr_q  (corr_o)
    );

    // outputs
    always_comb begin
        valid_o = (state_q == S_PUBLISH);
        error_o = err_q;
    end
endmodule

// File: rtl/refcal_checker.sv
module refcal_checker
    import refcal_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             valid,
    input logic             error,
    input logic [CNT_W-1:0] count,
    input state_t           state
);
    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> valid);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

    // R8
    err_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start) |=> (state == S_IDLE));
endmodule

bind refcal_top refcal_checker #(.CNT_W(CNT_W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .valid (valid_o),
    .error (error_o),
    .count (count_o),
    .state (state_q)
);

// File: tb/refcal_tb_top.sv
`timescale 1ns/1ps
module refcal_top_tb_top;
    localparam int CNT_W = 16;
    localparam int GATE  = 5;
    localparam int SHIFT = 2;
    localparam int NOM   = 70;
    localparam int TMO   = 60;
    localparam int NVEC  = 8;

    // period, high width, busy-start pulse index (-1 none), count, ref, corr
    localparam int VEC [NVEC][6] = '{
        '{10,  3, -1,  50, 12,  58},
        '{13,  3, -1,  65, 16,  54},
        '{20, 18, -1, 100, 25,  45},
        '{50,  2, -1, 250, 62,   8},
        '{55,  5, -1, 275, 68,   2},
        '{59,  1, -1, 295, 73,  -3},
        '{ 9,  1, -1,  45, 11,  59},
        '{10,  3,  3,  50, 12,  58}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pps = 1'b0;
    logic start = 1'b0;
    logic [CNT_W-1:0]       count;
    logic [CNT_W-SHIFT-1:0] ref_hz;
    logic signed [CNT_W:0]  corr;
    logic valid, error;

    int checks = 0;
    int errors = 0;
    int nvalid = 0;
    int v_cnt = 0, v_ref = 0, v_corr = 0, v_err = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    refcal_top #(
        .CNT_W(CNT_W), .GATE_PULSES(GATE), .SCALE_SHIFT(SHIFT),
        .NOMINAL(NOM), .PPS_TIMEOUT(TMO)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pps_in(pps), .start(start),
        .count_o(count), .ref_hz_o(ref_hz), .corr_o(corr),
        .valid_o(valid), .error_o(error)
    );

    always @(negedge clk) begin
        if (valid) begin
            nvalid++;
            v_cnt  = int'(count);
            v_ref  = int'(ref_hz);
            v_corr = int'(corr);
            v_err  = int'(error);
        end
    end

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pps_train(int per, int wid, int n, int xk);
        for (int k = 0; k < n; k++) begin
            for (int j = 0; j < per; j++) begin
                pps   = (j < wid);
                start = (k == xk) && (j == 0);
                @(negedge clk);
            end
        end
        pps = 1'b0;
        start = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 valid", int'(valid), 0);
        check("R1 error", int'(error), 0);
        check("R1 count", int'(count), 0);
        check("R1 ref", int'(ref_hz), 0);
        check("R1 corr", int'(corr), 0);

        // R2 pps while idle ignored
        nvalid = 0;
        pps_train(10, 3, GATE + 2, -1);
        idle(10);
        check("R2 no strobe idle", nvalid, 0);
        check("R2 no error idle", int'(error), 0);

        // vector walk: R3 R4 R5 R6 R7 R10
        for (int v = 0; v < NVEC; v++) begin
            nvalid = 0;
            pulse_start();
            pps_train(VEC[v][0], VEC[v][1], GATE + 1, VEC[v][2]);
            idle(10);
            check("R6 one strobe", nvalid, 1);
            check("R3 count", v_cnt, VEC[v][3]);
            check("R4 ref", v_ref, VEC[v][4]);
            check("R5 corr", v_corr, VEC[v][5]);
            check("R8 no error", v_err, 0);
            if (VEC[v][2] >= 0) check("R7 busy start ignored", v_cnt, VEC[v][3]);
            if (VEC[v][1] > 3) check("R10 wide pulse one edge", v_cnt, VEC[v][3]);
        end
        idle(5);
        check("R6 hold count", int'(count), 50);
        check("R6 hold corr", int'(corr), 58);

        // R2 start mid-stream: first edge after start opens window
        nvalid = 0;
        pps_train(10, 3, GATE + 3, 2);
        idle(10);
        check("R2 first edge after start", v_cnt, 50);
        check("R2 strobe count", nvalid, 1);

        // R8 abort inside GATE
        nvalid = 0;
        pulse_start();
        pps_train(13, 3, 2, -1);
        idle(100);
        check("R8 gate abort error", int'(error), 1);
        check("R8 no strobe on abort", nvalid, 0);
        check("R8 results kept", int'(count), 50);
        idle(20);
        check("R9 error sticky", int'(error), 1);

        // R9 start clears error; R8 abort in ARM
        pulse_start();
        check("R9 start clears", int'(error), 0);
        idle(100);
        check("R8 arm abort error", int'(error), 1);
        check("R8 arm no strobe", nvalid, 0);

        // recovery after error
        nvalid = 0;
        pulse_start();
        pps_train(20, 4, GATE + 1, -1);
        idle(10);
        check("R9 recovered error", int'(error), 0);
        check("R3 count after recovery", v_cnt, 100);
        check("R5 corr after recovery", v_corr, 45);

        report();
    end
endmodule